// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This unit lets a small 8-bit controller core read constant data from its own 16-bit program memory. When the core issues a table read, the unit builds a program-memory address from the table pointer byte and one of several sources for the upper bits. It fetches the word through a synchronous read port. It then stores the low byte at a data-memory location named with the request, and keeps the high byte in a latch that only table reads can change.

Two request forms exist. The page-local form takes the upper address bits from the program counter (or, in the wide variant, from a high-pointer byte). The last-page form forces every upper bit to one. The total address width is a parameter of 11 to 14 bits. The operation takes two cycles, and the unit holds a busy flag so that the core can stall until it ends.

Top module: `ptab_reader`

## Requirements
- R1: While rst_ni is low, and after it is released, busy_o, done_o, pmem_en_o and dmem_we_o are 0 and hi_byte_o is 0x00. A reset that comes after earlier reads also clears hi_byte_o.
- R2: In the narrow variant (HI_PTR_EN=0), a request with last_page_i=0 fetches from an address whose bits [7:0] equal tab_ptr_i and whose bits [ADDR_W-1:8] equal pc_i[ADDR_W-1:8]. This holds for ADDR_W of 11 and 13.
- R3: A request with last_page_i=1 fetches from an address whose bits [7:0] equal tab_ptr_i and whose bits [ADDR_W-1:8] are all 1. This holds in every variant.
- R4: In the wide variant (ADDR_W=14, HI_PTR_EN=1), a request with last_page_i=0 fetches from the address {hi_ptr_i[6:0], tab_ptr_i[6:0]}.
- R5: A request is accepted on a rising edge where req_i=1 and busy_o=0. In the first cycle after acceptance, pmem_en_o=1 and busy_o=1. In the second cycle, dmem_we_o=1, done_o=1 and busy_o=1. In the third cycle, busy_o=0. pmem_en_o and dmem_we_o are never high together.
- R6: In the write cycle, dmem_addr_o equals the dst_i given at acceptance, and dmem_wdata_o equals bits [7:0] of the fetched word.
- R7: From the cycle after the write cycle, hi_byte_o holds bits [15:8] of the fetched word. It keeps that value until the next completed read, whatever the other inputs do.
- R8: req_i is ignored while busy_o=1. The operation in progress completes unchanged, and no extra operation follows it.
- R9: tab_ptr_i, hi_ptr_i, pc_i, last_page_i and dst_i are sampled at acceptance. Changing them during the operation does not change its address, its destination or the data it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Table read request |
| last_page_i | input | 1 | 1: last-page form, 0: page-local form |
| dst_i | input | DST_W | Data-memory destination for the low byte |
| tab_ptr_i | input | 8 | Table pointer byte |
| hi_ptr_i | input | 8 | High pointer byte (wide variant only) |
| pc_i | input | ADDR_W | Current program counter |
| busy_o | output | 1 | Operation in progress; the core stalls |
| done_o | output | 1 | One-cycle strobe in the write cycle |
| pmem_en_o | output | 1 | Program-memory read enable |
| pmem_addr_o | output | ADDR_W | Program-memory read address |
| pmem_rdata_i | input | 16 | Program word, valid one cycle after pmem_en_o |
| dmem_we_o | output | 1 | Data-memory write enable |
| dmem_addr_o | output | DST_W | Data-memory write address |
| dmem_wdata_o | output | 8 | Data-memory write data (low byte) |
| hi_byte_o | output | 8 | Latched high byte of the last fetched word |

## Verification
The assertions assume that the program memory returns the addressed word in the cycle after pmem_en_o is high. They also assume that rst_ni is the only way to abandon an operation. The bench memory model is a registered read of a computed word, so every returned byte follows directly from the address. Inputs change only on falling edges. The bench deliberately holds req_i high and scrambles every operand during the operation, which is legal because the unit samples operands only at acceptance.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } ptab_state_e;
endpackage

// File: rtl/ptab_addr_gen.sv
module ptab_addr_gen #(
  parameter int unsigned ADDR_W    = 13,
  parameter bit          HI_PTR_EN = 1'b0
) (
  input  logic                         last_i,
  input  logic [ptab_pkg::BYTE_W-1:0]  ptr_i,
  input  logic [ptab_pkg::BYTE_W-1:0]  hi_ptr_i,
  input  logic [ADDR_W-1:0]            pc_i,
  output logic [ADDR_W-1:0]            addr_o
);
  import ptab_pkg::*;

  localparam int unsigned UP_W = ADDR_W - BYTE_W;
  localparam int unsigned HI_W = ADDR_W - (BYTE_W - 1);

  logic unused_ok;

  generate
    if (HI_PTR_EN) begin : g_hi
      // high pointer covers bit 7 in page-local form
      always_comb begin
        if (last_i) addr_o = {{UP_W{1'b1}}, ptr_i};
        else        addr_o = {hi_ptr_i[HI_W-1:0], ptr_i[BYTE_W-2:0]};
      end
      assign unused_ok = ^{pc_i, ptr_i[BYTE_W-1], hi_ptr_i[BYTE_W-1]};
    end else begin : g_pc
      always_comb begin
        if (last_i) addr_o = {{UP_W{1'b1}}, ptr_i};
        else        addr_o = {pc_i[ADDR_W-1:BYTE_W], ptr_i};
      end
      assign unused_ok = ^{hi_ptr_i};
    end
  endgenerate
endmodule

// File: rtl/ptab_seq.sv
module ptab_seq #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DST_W  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DST_W-1:0]             dst_i,
  input  logic [ptab_pkg::BYTE_W-1:0]  rdata_lo_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         pmem_en_o,
  output logic [ADDR_W-1:0]            pmem_addr_o,
  output logic                         dmem_we_o,
  output logic [DST_W-1:0]             dmem_addr_o,
  output logic [ptab_pkg::BYTE_W-1:0]  dmem_wdata_o,
  output logic                         hi_load_o
);
  import ptab_pkg::*;

  ptab_state_e         state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [DST_W-1:0]    dst_q;
  logic                accept;

  assign accept = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      dst_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_i;
        dst_q  <= dst_i;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign pmem_en_o    = (state_q == ST_FETCH);
  assign pmem_addr_o  = addr_q;
  assign dmem_we_o    = (state_q == ST_WRITE);
  assign done_o       = dmem_we_o;
  assign dmem_addr_o  = dst_q;
  assign dmem_wdata_o = rdata_lo_i;
  assign hi_load_o    = dmem_we_o;

  // R5
  accept_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (pmem_en_o && busy_o));
  // R5
  fetch_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_en_o |=> (dmem_we_o && done_o && busy_o));
  // R5
  write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R9
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(dmem_addr_o));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pmem_addr_o));
endmodule

// File: rtl/ptab_hi_latch.sv
module ptab_hi_latch (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [ptab_pkg::BYTE_W-1:0]  data_i,
  output logic [ptab_pkg::BYTE_W-1:0]  q_o
);
  import ptab_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= data_i;
  end

  // R7
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  // R7
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(data_i)));
endmodule

// File: rtl/ptab_reader.sv
module ptab_reader #(
  parameter int unsigned ADDR_W    = 13,
  parameter bit          HI_PTR_EN = 1'b0,
  parameter int unsigned DST_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               last_page_i,
  input  logic [DST_W-1:0]   dst_i,
  input  logic [7:0]         tab_ptr_i,
  input  logic [7:0]         hi_ptr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               pmem_en_o,
  output logic [ADDR_W-1:0]  pmem_addr_o,
  input  logic [15:0]        pmem_rdata_i,
  output logic               dmem_we_o,
  output logic [DST_W-1:0]   dmem_addr_o,
  output logic [7:0]         dmem_wdata_o,
  output logic [7:0]         hi_byte_o
);
  import ptab_pkg::*;

  generate
    if (ADDR_W < 11 || ADDR_W > 14) begin : g_bad_width
      $error("ptab_reader: ADDR_W must be 11..14");
    end
    if (HI_PTR_EN && ADDR_W != 14) begin : g_bad_variant
      $error("ptab_reader: high pointer variant needs ADDR_W=14");
    end
  endgenerate

  logic [ADDR_W-1:0] form_addr;
  logic              hi_load;

  ptab_addr_gen #(.ADDR_W(ADDR_W), .HI_PTR_EN(HI_PTR_EN)) u_addr (
    .last_i   (last_page_i),
    .ptr_i    (tab_ptr_i),
    .hi_ptr_i (hi_ptr_i),
    .pc_i     (pc_i),
    .addr_o   (form_addr)
  );

  ptab_seq #(.ADDR_W(ADDR_W), .DST_W(DST_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .addr_i       (form_addr),
    .dst_i        (dst_i),
    .rdata_lo_i   (pmem_rdata_i[BYTE_W-1:0]),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pmem_en_o    (pmem_en_o),
    .pmem_addr_o  (pmem_addr_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .hi_load_o    (hi_load)
  );

  ptab_hi_latch u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hi_load),
    .data_i (pmem_rdata_i[WORD_W-1:BYTE_W]),
    .q_o    (hi_byte_o)
  );

  // R5
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pmem_en_o, dmem_we_o}));
endmodule

// File: tb/ptab_reader_tb.sv
`timescale 1ns/1ps
module ptab_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req = 1'b0, last = 1'b0;
  logic [7:0]  dst = '0, ptr = '0, hip = '0;
  logic [13:0] pc = '0;

  logic        busy_a, done_a, pen_a, we_a;
  logic [12:0] paddr_a;
  logic [7:0]  daddr_a, wdat_a, hib_a;
  logic [15:0] rd_a;
  logic        busy_b, done_b, pen_b, we_b;
  logic [10:0] paddr_b;
  logic [7:0]  daddr_b, wdat_b, hib_b;
  logic [15:0] rd_b;
  logic        busy_c, done_c, pen_c, we_c;
  logic [13:0] paddr_c;
  logic [7:0]  daddr_c, wdat_c, hib_c;
  logic [15:0] rd_c;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  function automatic logic [15:0] mem_word(input logic [13:0] a);
    return {a[13:6] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  always_ff @(posedge clk) begin
    if (pen_a) rd_a <= mem_word(14'(paddr_a));
    if (pen_b) rd_b <= mem_word(14'(paddr_b));
    if (pen_c) rd_c <= mem_word(paddr_c);
  end

  ptab_reader #(.ADDR_W(13), .HI_PTR_EN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .last_page_i(last), .dst_i(dst),
    .tab_ptr_i(ptr), .hi_ptr_i(hip), .pc_i(pc[12:0]), .busy_o(busy_a), .done_o(done_a),
    .pmem_en_o(pen_a), .pmem_addr_o(paddr_a), .pmem_rdata_i(rd_a), .dmem_we_o(we_a),
    .dmem_addr_o(daddr_a), .dmem_wdata_o(wdat_a), .hi_byte_o(hib_a));

  ptab_reader #(.ADDR_W(11), .HI_PTR_EN(1'b0)) u_dut_n11 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .last_page_i(last), .dst_i(dst),
    .tab_ptr_i(ptr), .hi_ptr_i(hip), .pc_i(pc[10:0]), .busy_o(busy_b), .done_o(done_b),
    .pmem_en_o(pen_b), .pmem_addr_o(paddr_b), .pmem_rdata_i(rd_b), .dmem_we_o(we_b),
    .dmem_addr_o(daddr_b), .dmem_wdata_o(wdat_b), .hi_byte_o(hib_b));

  ptab_reader #(.ADDR_W(14), .HI_PTR_EN(1'b1)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .last_page_i(last), .dst_i(dst),
    .tab_ptr_i(ptr), .hi_ptr_i(hip), .pc_i(pc), .busy_o(busy_c), .done_o(done_c),
    .pmem_en_o(pen_c), .pmem_addr_o(paddr_c), .pmem_rdata_i(rd_c), .dmem_we_o(we_c),
    .dmem_addr_o(daddr_c), .dmem_wdata_o(wdat_c), .hi_byte_o(hib_c));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [13:0] exp_narrow(input int w, input logic l,
      input logic [7:0] p, input logic [13:0] c);
    logic [13:0] m = 14'((1 << w) - 1);
    return l ? ((m & ~14'h00FF) | 14'(p)) : ((c & m & ~14'h00FF) | 14'(p));
  endfunction

  function automatic logic [13:0] exp_wide(input logic l, input logic [7:0] p,
      input logic [7:0] h);
    return l ? (14'h3F00 | 14'(p)) : {h[6:0], p[6:0]};
  endfunction

  // one complete read with req held and operands scrambled mid-operation
  task automatic run_read(input string atag, input string wtag, input logic l,
      input logic [7:0] d, input logic [7:0] p, input logic [7:0] h, input logic [13:0] c);
    logic [13:0] ea = exp_narrow(13, l, p, c);
    logic [13:0] eb = exp_narrow(11, l, p, c);
    logic [13:0] ec = exp_wide(l, p, h);
    @(negedge clk);
    req = 1'b1; last = l; dst = d; ptr = p; hip = h; pc = c;
    @(negedge clk);
    chk("R5 busy in fetch", 16'(busy_a & busy_b & busy_c), 16'd1);
    chk("R5 pmem_en in fetch", 16'(pen_a & pen_b & pen_c), 16'd1);
    chk("R5 no write in fetch", 16'(we_a | we_b | we_c), 16'd0);
    chk({atag, " addr 13b"}, 16'(paddr_a), 16'(ea[12:0]));
    chk({atag, " addr 11b"}, 16'(paddr_b), 16'(eb[10:0]));
    chk({wtag, " addr wide"}, 16'(paddr_c), 16'(ec));
    last = ~l; dst = ~d; ptr = ~p; hip = ~h; pc = ~c;
    @(negedge clk);
    chk("R8 write cycle follows", 16'(we_a & we_b & we_c & done_a & done_b & done_c), 16'd1);
    chk("R5 pmem_en low in write", 16'(pen_a | pen_b | pen_c), 16'd0);
    chk("R9 dst sampled", {daddr_a, daddr_c}, {d, d});
    chk("R6 dst 11b", 16'(daddr_b), 16'(d));
    chk("R6 low byte 13b", 16'(wdat_a), 16'(mem_word(ea)) & 16'h00FF);
    chk("R6 low byte 11b", 16'(wdat_b), 16'(mem_word(eb)) & 16'h00FF);
    chk("R9 low byte wide", 16'(wdat_c), 16'(mem_word(ec)) & 16'h00FF);
    req = 1'b0;
    @(negedge clk);
    chk("R5 idle after write", 16'(busy_a | busy_b | busy_c | done_a | we_a), 16'd0);
    chk("R7 high byte 13b", 16'(hib_a), 16'(mem_word(ea) >> 8));
    chk("R7 high byte 11b", 16'(hib_b), 16'(mem_word(eb) >> 8));
    chk("R7 high byte wide", 16'(hib_c), 16'(mem_word(ec) >> 8));
  endtask

  task automatic t_reset;
    #5;
    chk("R1 reset outputs", 16'({busy_a, done_a, pen_a, we_a, busy_c, we_c}), 16'd0);
    chk("R1 reset high byte", {hib_a, hib_c}, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 16'({busy_a, done_a, pen_a, we_a, busy_b}), 16'd0);
  endtask

  task automatic t_page_local;
    run_read("R2", "R4", 1'b0, 8'h12, 8'h34, 8'h56, 14'h1A78);
    run_read("R2", "R4", 1'b0, 8'hF0, 8'hFF, 8'h7F, 14'h0000);
    run_read("R2", "R4", 1'b0, 8'h01, 8'h80, 8'h81, 14'h3FFF);
    run_read("R2", "R4", 1'b0, 8'h00, 8'h00, 8'h00, 14'h2500);
  endtask

  task automatic t_last_page;
    run_read("R3", "R3", 1'b1, 8'h44, 8'hC7, 8'h12, 14'h0123);
    run_read("R3", "R3", 1'b1, 8'hFF, 8'h00, 8'hFF, 14'h3FFF);
    run_read("R3", "R3", 1'b1, 8'h9A, 8'h5B, 8'h00, 14'h0000);
  endtask

  task automatic t_hold;
    logic [7:0] ha = hib_a, hc = hib_c;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ptr = 8'(i * 37); hip = 8'(i * 11); pc = 14'(i * 999); dst = 8'(i); last = i[0];
      rd_a = 16'hBEEF; rd_c = 16'hCAFE;
    end
    @(negedge clk);
    chk("R7 high byte held", {hib_a, hib_c}, {ha, hc});
    chk("R7 no write while idle", 16'(we_a | we_c | busy_a), 16'd0);
  endtask

  task automatic t_rereset;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 re-reset clears high byte", {hib_a, hib_b}, 16'd0);
    chk("R1 re-reset clears wide", 16'(hib_c), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_read("R2", "R4", 1'b0, 8'h2D, 8'h6E, 8'h3B, 14'h0F00);
  endtask

  initial begin
    t_reset();
    t_page_local();
    t_last_page();
    t_hold();
    t_rereset();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule